// File: doc/BRIEF.md
# Single-Line Dirty Victim Write-Back Buffer

This block sits between a write-back data cache controller and the shared external memory bus. When the controller evicts a modified line, it hands the whole line over in one transfer: the line address (bits 31 down to 4) and four 32-bit words. The controller can then start fetching the replacement line at once. The buffer keeps the victim and does not touch memory until the controller reports that the refill has finished.

After that report, the buffer writes the line out as four single-word write beats, word 0 first. The external bus is shared with the refill path. A refill request always wins arbitration. If a refill request arrives while the line is draining, the write beat on the bus completes, the refill burst runs, and the drain then continues with the next word. The cache keeps serving hits throughout, because nothing on the hit path waits for the buffer.

Only one line is held. While the line is held, the eviction handshake reports not-ready, so a second eviction stalls the controller until the last beat of the current line has been acknowledged.

Top module: `wb_evict_buf`

## Requirements
- R1: After reset, `full` is 0, `ev_ready` is 1, `mem_req` is 0 and `rf_gnt` is 0.
- R2: A handoff (`ev_valid` and `ev_ready` both high at a clock edge) captures `ev_addr` and `ev_line` and sets `full` from the next cycle. While `full` is 1, `ev_ready` is 0 and a waiting handoff is not taken until the line has drained.
- R3: A captured line produces no write beat until `refill_done` has been seen high while `full` is 1.
- R4: The drain is four write beats (`mem_we`=1) in the order word 0, 1, 2, 3. Word k is taken from `ev_line[32k+31:32k]`, and beat k has address bits [3:2] = k and bits [1:0] = 0.
- R5: During a drain beat, `mem_addr` is {3'b000, captured address bits 28..4, beat index, 2'b00}. The top three address bits are always 0.
- R6: When the bus is idle and `rf_req` is high, the refill path is granted even if a drain is pending, including in the same cycle that `refill_done` arrives.
- R7: A drain beat that is on the bus holds its address, data and request until `mem_ack`. A refill request that arrives mid-drain is granted at the next beat boundary, and the drain resumes with the following word after `rf_req` falls.
- R8: `full` falls and `ev_ready` rises in the cycle after the acknowledge of the fourth write beat.
- R9: A `refill_done` pulse while the buffer is empty has no effect. A line captured afterwards still waits for its own `refill_done`.
- R10: While `rf_gnt` is high, `mem_addr` follows `rf_addr`, `mem_we` is 0, `mem_req` follows `rf_req`, and `rf_ack` reflects `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | Controller offers an evicted dirty line |
| ev_ready | output | 1 | Buffer can take a line (empty) |
| ev_addr | input | 28 | Line address bits 31..4 |
| ev_line | input | 128 | Four words, word k in bits 32k+31..32k |
| refill_done | input | 1 | Pulse: the controller has finished fetching the new line |
| rf_req | input | 1 | Refill path requests the external bus |
| rf_addr | input | 32 | Refill read address |
| rf_gnt | output | 1 | Refill path owns the bus |
| rf_ack | output | 1 | Acknowledge for a refill beat |
| full | output | 1 | A line is held |
| mem_req | output | 1 | External bus request |
| mem_we | output | 1 | External bus write enable |
| mem_addr | output | 32 | External bus address |
| mem_wdata | output | 32 | External bus write data |
| mem_ack | input | 1 | External bus beat acknowledge |

## Verification
The hardest case to reach from the ports is a refill that cuts into a drain already under way. The stimulus waits until exactly one write beat has been acknowledged, then raises the refill request during the idle cycle at the beat boundary. It then checks that the bus log reads word 0, the refill beats, and words 1 to 3. A second hard case is a refill request that rises in the same cycle as `refill_done`. The bench drives both together and expects the refill to take the bus before any write beat.

// File: rtl/wbb_pkg.sv
package wbb_pkg;
    typedef enum logic [1:0] {
        OWN_NONE   = 2'd0,
        OWN_REFILL = 2'd1,
        OWN_DRAIN  = 2'd2
    } owner_e;
endpackage

// File: rtl/wbb_line_store.sv
module wbb_line_store #(
    parameter int TAG_W  = 28,
    parameter int DATA_W = 32,
    parameter int BEATS  = 4,
    localparam int BEAT_W = $clog2(BEATS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic [TAG_W-1:0]        tag_i,
    input  logic [BEATS*DATA_W-1:0] line_i,
    input  logic [BEAT_W-1:0]       beat_i,
    output logic [TAG_W-1:0]        tag_o,
    output logic [DATA_W-1:0]       word_o
);
    typedef struct packed {
        logic [TAG_W-1:0]             tag;
        logic [BEATS-1:0][DATA_W-1:0] words;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.tag = tag_i;
            for (int k = 0; k < BEATS; k++) begin
                st_d.words[k] = line_i[k*DATA_W +: DATA_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tag_o  = st_q.tag;
    assign word_o = st_q.words[beat_i];
endmodule

// File: rtl/wbb_drain_ctl.sv
module wbb_drain_ctl #(
    parameter int BEATS = 4,
    localparam int BEAT_W = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid_i,
    input  logic              refill_done_i,
    input  logic              beat_ack_i,
    output logic              load_o,
    output logic              full_o,
    output logic              armed_o,
    output logic [BEAT_W-1:0] beat_o
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    typedef struct packed {
        logic              full;
        logic              armed;
        logic [BEAT_W-1:0] beat;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic load;

    assign load = ev_valid_i && !ctl_q.full;

    always_comb begin
        ctl_d = ctl_q;
        if (load) begin
            ctl_d.full  = 1'b1;
            ctl_d.armed = 1'b0;
            ctl_d.beat  = '0;
        end
        if (ctl_q.full && refill_done_i) begin
            ctl_d.armed = 1'b1;
        end
        if (ctl_q.full && beat_ack_i) begin
            if (ctl_q.beat == LAST_BEAT) begin
                ctl_d.full  = 1'b0;
                ctl_d.armed = 1'b0;
                ctl_d.beat  = '0;
            end else begin
                ctl_d.beat = ctl_q.beat + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign load_o  = load;
    assign full_o  = ctl_q.full;
    assign armed_o = ctl_q.armed;
    assign beat_o  = ctl_q.beat;
endmodule

// File: rtl/wbb_bus_arb.sv
module wbb_bus_arb
    import wbb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   rf_req_i,
    input  logic   drain_want_i,
    input  logic   mem_ack_i,
    output owner_e own_o
);
    typedef struct packed {
        owner_e own;
    } arb_t;

    arb_t arb_d, arb_q;

    always_comb begin
        arb_d = arb_q;
        unique case (arb_q.own)
            OWN_NONE: begin
                if (rf_req_i)          arb_d.own = OWN_REFILL;
                else if (drain_want_i) arb_d.own = OWN_DRAIN;
            end
            OWN_REFILL: begin
                if (!rf_req_i) arb_d.own = OWN_NONE;
            end
            OWN_DRAIN: begin
                if (mem_ack_i) arb_d.own = OWN_NONE;
            end
            default: arb_d.own = OWN_NONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arb_q.own <= OWN_NONE;
        else        arb_q     <= arb_d;
    end

    assign own_o = arb_q.own;
endmodule

// File: rtl/wb_evict_buf.sv
module wb_evict_buf
    import wbb_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int BEATS   = 4,
    parameter int ZERO_HI = 3,
    localparam int BEAT_W = $clog2(BEATS),
    localparam int OFS_W  = $clog2(DATA_W / 8),
    localparam int LINE_W = BEAT_W + OFS_W,
    localparam int TAG_W  = ADDR_W - LINE_W,
    localparam int KEEP_W = TAG_W - ZERO_HI
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ev_valid,
    output logic                    ev_ready,
    input  logic [TAG_W-1:0]        ev_addr,
    input  logic [BEATS*DATA_W-1:0] ev_line,
    input  logic                    refill_done,
    input  logic                    rf_req,
    input  logic [ADDR_W-1:0]       rf_addr,
    output logic                    rf_gnt,
    output logic                    rf_ack,
    output logic                    full,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    input  logic                    mem_ack
);
    owner_e              own;
    logic                load;
    logic                full_w;
    logic                armed;
    logic [BEAT_W-1:0]   beat;
    logic [TAG_W-1:0]    tag;
    logic [DATA_W-1:0]   word;
    logic [ADDR_W-1:0]   drain_addr;
    logic                beat_ack;

    assign beat_ack = mem_ack && (own == OWN_DRAIN);

    wbb_drain_ctl #(.BEATS(BEATS)) u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .ev_valid_i    (ev_valid),
        .refill_done_i (refill_done),
        .beat_ack_i    (beat_ack),
        .load_o        (load),
        .full_o        (full_w),
        .armed_o       (armed),
        .beat_o        (beat)
    );

    wbb_line_store #(.TAG_W(TAG_W), .DATA_W(DATA_W), .BEATS(BEATS)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .tag_i  (ev_addr),
        .line_i (ev_line),
        .beat_i (beat),
        .tag_o  (tag),
        .word_o (word)
    );

    wbb_bus_arb u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .rf_req_i     (rf_req),
        .drain_want_i (armed && full_w),
        .mem_ack_i    (mem_ack),
        .own_o        (own)
    );

    // Drain address: forced-zero top bits, kept tag bits, beat index, byte offset.
    generate
        if (ZERO_HI > 0) begin : g_zero_hi
            logic unused_tag_hi;
            assign unused_tag_hi = ^tag[TAG_W-1 -: ZERO_HI];
            assign drain_addr = {{ZERO_HI{1'b0}}, tag[KEEP_W-1:0], beat, {OFS_W{1'b0}}};
        end else begin : g_full_tag
            assign drain_addr = {tag, beat, {OFS_W{1'b0}}};
        end
    endgenerate

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        rf_gnt    = 1'b0;
        rf_ack    = 1'b0;
        unique case (own)
            OWN_REFILL: begin
                rf_gnt   = 1'b1;
                mem_req  = rf_req;
                mem_addr = rf_addr;
                rf_ack   = mem_ack;
            end
            OWN_DRAIN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = drain_addr;
                mem_wdata = word;
            end
            default: ;
        endcase
    end

    assign full     = full_w;
    assign ev_ready = !full_w;
endmodule

// File: rtl/wbb_chk.sv
module wbb_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_valid,
    input logic              ev_ready,
    input logic              refill_done,
    input logic              rf_req,
    input logic [ADDR_W-1:0] rf_addr,
    input logic              rf_gnt,
    input logic              full,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack
);
    logic seen_done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    seen_done_q <= 1'b0;
        else if (!full)                seen_done_q <= 1'b0;
        else if (refill_done)          seen_done_q <= 1'b1;
    end

    // R2
    take_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready) |=> full);

    // R3
    no_early_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> seen_done_q);

    // R5
    top_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr[ADDR_W-1 -: 3] == 3'b000 && mem_addr[1:0] == 2'b00));

    // R7
    beat_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_ack) |=> (mem_req && mem_we && $stable(mem_addr)));

    // R8
    last_beat_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack && mem_addr[3:2] == 2'd3) |=> (!full && ev_ready));

    // R10
    refill_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_gnt |-> (!mem_we && mem_req == rf_req && mem_addr == rf_addr));
endmodule

bind wb_evict_buf wbb_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_valid    (ev_valid),
    .ev_ready    (ev_ready),
    .refill_done (refill_done),
    .rf_req      (rf_req),
    .rf_addr     (rf_addr),
    .rf_gnt      (rf_gnt),
    .full        (full),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_ack     (mem_ack)
);

// File: tb/wb_evict_buf_test.sv
module wb_evict_buf_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 4;
    localparam logic [27:0] T_ADDR [NV] = '{28'h0001234, 28'hFFFFFFF, 28'hA5A5A5A, 28'h0000000};
    localparam logic [31:0] T_SEED [NV] = '{32'h11223344, 32'hDEADBEEF, 32'h00000000, 32'hFFFFFFFF};

    logic         clk = 0;
    logic         rst_n = 0;
    logic         ev_valid = 0;
    logic         ev_ready;
    logic [27:0]  ev_addr = '0;
    logic [127:0] ev_line = '0;
    logic         refill_done = 0;
    logic         rf_req = 0;
    logic [31:0]  rf_addr = '0;
    logic         rf_gnt, rf_ack, full, mem_req, mem_we;
    logic [31:0]  mem_addr, mem_wdata;
    logic         mem_ack = 0;

    int total = 0;
    int bad = 0;
    int log_n = 0;
    int rfack_n = 0;
    logic [31:0] log_addr [64];
    logic [31:0] log_data [64];
    logic        log_we   [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    wb_evict_buf uut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_addr(ev_addr), .ev_line(ev_line), .refill_done(refill_done),
        .rf_req(rf_req), .rf_addr(rf_addr), .rf_gnt(rf_gnt), .rf_ack(rf_ack),
        .full(full), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack)
    );

    // Memory model: acknowledge each request one edge after it is seen, log it.
    always @(negedge clk) begin
        if (!rst_n) mem_ack = 1'b0;
        else if (mem_ack) mem_ack = 1'b0;
        else if (mem_req) begin
            mem_ack = 1'b1;
            if (log_n < 64) begin
                log_addr[log_n] = mem_addr;
                log_data[log_n] = mem_wdata;
                log_we[log_n]   = mem_we;
                log_n++;
            end
        end
    end

    always @(posedge clk) if (rf_ack) rfack_n++;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [127:0] mk_line(input logic [31:0] seed);
        logic [127:0] l;
        for (int k = 0; k < 4; k++) l[k*32 +: 32] = seed + 32'(k) * 32'h10203041;
        return l;
    endfunction

    function automatic logic [31:0] exp_addr(input logic [27:0] a, input int k);
        return {3'b000, a[24:0], 2'(k), 2'b00};
    endfunction

    task automatic capture(input logic [27:0] a, input logic [127:0] l);
        @(negedge clk);
        ev_valid = 1; ev_addr = a; ev_line = l;
        while (!ev_ready) @(negedge clk);
        @(negedge clk);
        ev_valid = 0;
    endtask

    task automatic pulse_done();
        @(negedge clk); refill_done = 1;
        @(negedge clk); refill_done = 0;
    endtask

    task automatic wait_log(input int n);
        while (log_n < n) @(posedge clk);
    endtask

    task automatic chk_beats(input int base, input logic [27:0] a, input logic [127:0] l);
        for (int k = 0; k < 4; k++) begin
            chk("R4", $sformatf("beat%0d we", k), 64'(log_we[base+k]), 64'(1'b1));
            chk("R5", $sformatf("beat%0d addr", k), 64'(log_addr[base+k]), 64'(exp_addr(a, k)));
            chk("R4", $sformatf("beat%0d data", k), 64'(log_data[base+k]), 64'(l[k*32 +: 32]));
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        int base;
        logic [127:0] la, lb;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "full", 64'(full), 64'(0));
        chk("R1", "ev_ready", 64'(ev_ready), 64'(1));
        chk("R1", "mem_req", 64'(mem_req), 64'(0));
        chk("R1", "rf_gnt", 64'(rf_gnt), 64'(0));
        rst_n = 1;

        // Table walk: capture, hold, drain, free
        for (int i = 0; i < NV; i++) begin
            base = log_n;
            capture(T_ADDR[i], mk_line(T_SEED[i]));
            chk("R2", "full after take", 64'(full), 64'(1));
            chk("R2", "ready while full", 64'(ev_ready), 64'(0));
            repeat (6) @(negedge clk);
            chk("R3", "no beat before done", 64'(log_n), 64'(base));
            pulse_done();
            wait_log(base + 4);
            @(negedge clk);
            chk("R8", "full cleared", 64'(full), 64'(0));
            chk("R8", "ready back", 64'(ev_ready), 64'(1));
            chk_beats(base, T_ADDR[i], mk_line(T_SEED[i]));
        end

        // R9: done pulse while empty is ignored
        pulse_done();
        base = log_n;
        la = mk_line(32'h0BADF00D);
        capture(28'h1357BDF, la);
        repeat (8) @(negedge clk);
        chk("R9", "stale done ignored", 64'(log_n), 64'(base));
        pulse_done();
        wait_log(base + 4);
        chk_beats(base, 28'h1357BDF, la);

        // R2: second handoff stalls until drain ends
        base = log_n;
        la = mk_line(32'hCAFE0000);
        lb = mk_line(32'h55550001);
        capture(28'h0ABCDEF, la);
        @(negedge clk);
        ev_valid = 1; ev_addr = 28'h0FEDCBA; ev_line = lb;
        repeat (3) @(negedge clk);
        chk("R2", "stall ready low", 64'(ev_ready), 64'(0));
        pulse_done();
        wait_log(base + 4);
        @(negedge clk);
        while (!ev_ready) @(negedge clk);
        @(negedge clk);
        ev_valid = 0;
        chk("R2", "held handoff taken", 64'(full), 64'(1));
        chk_beats(base, 28'h0ABCDEF, la);
        base = log_n;
        pulse_done();
        wait_log(base + 4);
        chk_beats(base, 28'h0FEDCBA, lb);

        // R6: refill request together with refill_done wins the bus
        base = log_n;
        la = mk_line(32'h76543210);
        rfack_n = 0;
        capture(28'h0123456, la);
        @(negedge clk);
        refill_done = 1; rf_req = 1; rf_addr = 32'h1000_0040;
        @(negedge clk);
        refill_done = 0;
        wait_log(base + 2);
        @(negedge clk);
        rf_req = 0;
        wait_log(base + 6);
        @(negedge clk);
        chk("R6", "first beat is refill", 64'(log_we[base]), 64'(0));
        chk("R10", "refill addr", 64'(log_addr[base]), 64'(32'h1000_0040));
        chk("R10", "refill ack count", 64'(rfack_n), 64'(2));
        chk_beats(base + 2, 28'h0123456, la);

        // R7: refill cuts in after word 0, drain resumes with word 1
        base = log_n;
        la = mk_line(32'h89ABCDEF);
        capture(28'hE000123, la);
        pulse_done();
        wait_log(base + 1);
        @(negedge clk);
        rf_req = 1; rf_addr = 32'h2000_0080;
        wait_log(base + 3);
        @(negedge clk);
        rf_req = 0;
        wait_log(base + 6);
        @(negedge clk);
        chk("R7", "word0 first", 64'(log_addr[base]), 64'(exp_addr(28'hE000123, 0)));
        chk("R7", "refill beat a", 64'(log_we[base+1]), 64'(0));
        chk("R7", "refill beat b", 64'(log_we[base+2]), 64'(0));
        chk("R7", "resume word1 addr", 64'(log_addr[base+3]), 64'(exp_addr(28'hE000123, 1)));
        chk("R7", "resume word1 data", 64'(log_data[base+3]), 64'(la[63:32]));
        chk("R7", "word3 last", 64'(log_addr[base+5]), 64'(exp_addr(28'hE000123, 3)));
        chk("R8", "empty after resumed drain", 64'(full), 64'(0));

        finish_run();
    end
endmodule